// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the interrupt sources of a small 8-bit processor core into one level request and supplies a fixed 16-bit vector address for the source being serviced. Three sources have their own flag and enable: an external request pin, a timer overflow and an edge on an external clock pin. A group of peripheral sources shares one vector. Each peripheral has its own flag and enable, and one group enable gates the whole group. A global disable bit blocks every request. This bit comes up set. It is set again by hardware whenever the core takes an interrupt, and it is cleared by the core's return-from-interrupt strobe.

The core samples `irqReq`. When it decides to take the interrupt it pulses `irqAck` for one cycle. In that cycle the controller latches the vector of the highest-priority enabled pending source and sets the global disable bit. The vector stays on `irqVector` until the next accepted acknowledge. Software reaches the bits through a write strobe with a 2-bit register select and a combinational read port. No flag is ever cleared by hardware, so the service routine must clear the flags it has handled before it returns.

Top module: `irq_vec_top`

## Requirements
- R1: After reset the global disable bit reads 1, every enable and flag reads 0, `irqVector` is 0x0000 and `irqReq` is low.
- R2: `irqReq` is high exactly when the global disable bit is clear and at least one enabled source is pending. While the disable bit is set, `irqReq` stays low.
- R3: A source event sets its flag whatever the state of its own enable and of the global disable bit. An event wins over a software write that clears the same flag in the same cycle.
- R4: An acknowledge while `irqReq` is high is accepted. On the next cycle the global disable bit reads 1 and `irqReq` is low. An acknowledge while `irqReq` is low is ignored and leaves `irqVector` unchanged.
- R5: A pulse on `irqRet` clears the global disable bit.
- R6: The vectors are fixed: external pin 0x0008, timer overflow 0x0010, clock-pin edge 0x0018, peripheral group 0x0020.
- R7: When several enabled sources are pending together, the vector latched is the one of the highest priority. The order is pin, then timer, then clock edge, then peripheral group.
- R8: A peripheral flag makes a request only when both its own enable and the group enable are set. The group flag (flag register bit 3) reads as the OR over the peripherals of flag AND enable. It is read-only.
- R9: Hardware never clears a flag. A flag left set causes a new request as soon as the return strobe clears the global disable bit.
- R10: `irqVector` changes only on an accepted acknowledge. It holds even when a different source becomes the highest-priority pending one.
- R11: A software write that sets the global disable bit in the same cycle as an acknowledge wins. The acknowledge is not accepted and `irqVector` keeps its value.
- R12: Register map, chosen by `regSel`:
  - 0, control: bit0 global disable, bit1 group enable, bit2 pin enable, bit3 timer enable, bit4 clock-edge enable.
  - 1, flags: bit0 pin, bit1 timer, bit2 clock edge, bit3 group (read-only).
  - 2: peripheral flags, one bit per peripheral.
  - 3: peripheral enables, one bit per peripheral.
  - Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPin | input | 1 | External pin request event, one-cycle pulse |
| evtTimer | input | 1 | Timer overflow event, one-cycle pulse |
| evtClkEdge | input | 1 | External clock-pin edge event, one-cycle pulse |
| periphFlagSet | input | NUM_PERIPH | Per-peripheral event pulses |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data of the selected register |
| irqAck | input | 1 | Core takes the interrupt |
| irqRet | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Level interrupt request to the core |
| irqVector | output | VEC_W | Vector latched at the last accepted acknowledge |

## Verification
The main function is tried with a table of source patterns:
- all four sources pending at once, and adjacent pairs of sources, which separates a correct priority order from a reversed or shifted one;
- a single source at a time, which pins each vector address on its own;
- a higher-priority source that is flagged but not enabled, which shows that the enable takes part in the choice and does more than hide the request;
- peripheral patterns with the group enable off or the individual enable off, which tell the two gates apart.

Directed cases then cover an event colliding with a software clear, an acknowledge colliding with a write that sets the disable bit, an acknowledge with no request, and a flag left set across a return.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Number of prioritized request lines (pin, timer, clock edge, peripheral group)
  localparam int NUM_SRC = 4;

  // Source index doubles as priority: lower index wins
  localparam int SRC_PIN    = 0;
  localparam int SRC_TIMER  = 1;
  localparam int SRC_CLKEDG = 2;
  localparam int SRC_GROUP  = 3;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FLAG  = 2'd1,
    SEL_PFLAG = 2'd2,
    SEL_PEN   = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic wrCtrl;
    logic wrFlag;
    logic wrPFlag;
    logic wrPEn;
  } dpStrobe_t;

endpackage

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqAck,
  input  logic      irqRet,
  input  logic      regWrEn,
  input  logic [1:0] regSel,
  input  logic      wrDisBit,
  input  logic      anyPending,
  output dpStrobe_t strobe,
  output logic      glbDisable,
  output logic      irqReq
);

  logic wrCtrlHit;
  logic disSetByWrite;
  logic accept;

  always_comb begin
    wrCtrlHit     = regWrEn && (regSel_e'(regSel) == SEL_CTRL);
    disSetByWrite = wrCtrlHit && wrDisBit;
    irqReq        = anyPending && !glbDisable;
    // A write that sets the disable bit wins over a simultaneous acknowledge
    accept        = irqAck && irqReq && !disSetByWrite;
  end

  always_comb begin
    strobe.accept  = accept;
    strobe.wrCtrl  = wrCtrlHit;
    strobe.wrFlag  = regWrEn && (regSel_e'(regSel) == SEL_FLAG);
    strobe.wrPFlag = regWrEn && (regSel_e'(regSel) == SEL_PFLAG);
    strobe.wrPEn   = regWrEn && (regSel_e'(regSel) == SEL_PEN);
  end

  // Accept sets; a software write comes next; the return strobe clears last
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbDisable <= 1'b1;
    end else if (accept) begin
      glbDisable <= 1'b1;
    end else if (wrCtrlHit) begin
      glbDisable <= wrDisBit;
    end else if (irqRet) begin
      glbDisable <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_vec_dpath.sv
module irq_vec_dpath
  import irq_vec_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 0,
  parameter int VEC_STRIDE = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evtPin,
  input  logic                  evtTimer,
  input  logic                  evtClkEdge,
  input  logic [NUM_PERIPH-1:0] periphFlagSet,
  input  dpStrobe_t             strobe,
  input  logic [1:0]            regSel,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  glbDisable,
  output logic                  anyPending,
  output logic [DATA_W-1:0]     regRdData,
  output logic [VEC_W-1:0]      irqVector
);

  localparam int NUM_DED = NUM_SRC - 1;
  localparam int SEL_W   = $clog2(NUM_SRC);
  // Control register bit positions
  localparam int CB_DIS  = 0;
  localparam int CB_GRP  = 1;
  localparam int CB_EN0  = 2;

  logic [NUM_DED-1:0]    dedFlag;
  logic [NUM_DED-1:0]    dedEn;
  logic [NUM_DED-1:0]    dedEvt;
  logic                  grpEn;
  logic [NUM_PERIPH-1:0] pFlag;
  logic [NUM_PERIPH-1:0] pEn;
  logic                  grpFlag;
  logic [NUM_SRC-1:0]    pending;
  logic [SEL_W-1:0]      winIdx;
  logic [VEC_W-1:0]      winVec;
  logic [VEC_W-1:0]      vecReg;

  assign dedEvt = {evtClkEdge, evtTimer, evtPin};

  // Dedicated source flags: an event overrides a same-cycle software write
  for (genvar gi = 0; gi < NUM_DED; gi++) begin : g_ded
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dedFlag[gi] <= 1'b0;
      end else if (dedEvt[gi]) begin
        dedFlag[gi] <= 1'b1;
      end else if (strobe.wrFlag) begin
        dedFlag[gi] <= regWrData[gi];
      end
    end
  end

  // Peripheral flags, same rule
  for (genvar gp = 0; gp < NUM_PERIPH; gp++) begin : g_per
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pFlag[gp] <= 1'b0;
      end else if (periphFlagSet[gp]) begin
        pFlag[gp] <= 1'b1;
      end else if (strobe.wrPFlag) begin
        pFlag[gp] <= regWrData[gp];
      end
    end
  end

  // Enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpEn <= 1'b0;
      dedEn <= '0;
      pEn   <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        grpEn <= regWrData[CB_GRP];
        dedEn <= regWrData[CB_EN0 +: NUM_DED];
      end
      if (strobe.wrPEn) begin
        pEn <= regWrData[NUM_PERIPH-1:0];
      end
    end
  end

  // Group request and per-source pending vector
  always_comb begin
    grpFlag = |(pFlag & pEn);
    pending = {grpFlag & grpEn, dedFlag & dedEn};
    anyPending = |pending;
  end

  // Fixed priority: scan from lowest priority so the lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        winIdx = SEL_W'(i);
      end
    end
    winVec = VEC_W'(VEC_BASE + (int'(winIdx) + 1) * VEC_STRIDE);
  end

  // Vector latched on an accepted acknowledge only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg <= '0;
    end else if (strobe.accept) begin
      vecReg <= winVec;
    end
  end

  assign irqVector = vecReg;

  // Read mux
  always_comb begin
    regRdData = '0;
    unique case (regSel_e'(regSel))
      SEL_CTRL: begin
        regRdData[CB_DIS]             = glbDisable;
        regRdData[CB_GRP]             = grpEn;
        regRdData[CB_EN0 +: NUM_DED]  = dedEn;
      end
      SEL_FLAG: begin
        regRdData[NUM_DED-1:0] = dedFlag;
        regRdData[NUM_DED]     = grpFlag;
      end
      SEL_PFLAG: regRdData[NUM_PERIPH-1:0] = pFlag;
      SEL_PEN:   regRdData[NUM_PERIPH-1:0] = pEn;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_vec_top.sv
module irq_vec_top
  import irq_vec_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 0,
  parameter int VEC_STRIDE = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evtPin,
  input  logic                  evtTimer,
  input  logic                  evtClkEdge,
  input  logic [NUM_PERIPH-1:0] periphFlagSet,
  input  logic                  regWrEn,
  input  logic [1:0]            regSel,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  irqAck,
  input  logic                  irqRet,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVector
);

  dpStrobe_t strobe;
  logic      glbDisable;
  logic      anyPending;

  irq_vec_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .irqAck     (irqAck),
    .irqRet     (irqRet),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .wrDisBit   (regWrData[0]),
    .anyPending (anyPending),
    .strobe     (strobe),
    .glbDisable (glbDisable),
    .irqReq     (irqReq)
  );

  irq_vec_dpath #(
    .NUM_PERIPH (NUM_PERIPH),
    .DATA_W     (DATA_W),
    .VEC_W      (VEC_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .evtPin        (evtPin),
    .evtTimer      (evtTimer),
    .evtClkEdge    (evtClkEdge),
    .periphFlagSet (periphFlagSet),
    .strobe        (strobe),
    .regSel        (regSel),
    .regWrData     (regWrData),
    .glbDisable    (glbDisable),
    .anyPending    (anyPending),
    .regRdData     (regRdData),
    .irqVector     (irqVector)
  );

endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int DATA_W = 8,
  parameter int VEC_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic [DATA_W-1:0] regWrData,
  input logic              irqAck,
  input logic              irqRet,
  input logic              irqReq,
  input logic [VEC_W-1:0]  irqVector,
  input logic              glbDisable
);

  logic wrCtrl;
  assign wrCtrl = regWrEn && (regSel == 2'd0);

  // R2: no request while globally disabled
  a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    glbDisable |-> !irqReq);

  // R4: an accepted acknowledge sets the global disable bit
  a_r4_accept_disables: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && !(wrCtrl && regWrData[0])) |=> glbDisable);

  // R5: return strobe clears the disable bit when nothing else competes
  a_r5_return_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqRet && !(irqAck && irqReq) && !wrCtrl) |=> !glbDisable);

  // R10: the vector moves only on an acknowledge that met a request
  a_r10_vector_held: assert property (@(posedge clk) disable iff (!rstN)
    !(irqAck && irqReq) |=> $stable(irqVector));

  // R11: a disable-setting write beats a same-cycle acknowledge
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && wrCtrl && regWrData[0]) |=> (glbDisable && $stable(irqVector)));

  // R6: the vector only ever holds reset value or one of the four addresses
  a_r6_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    (irqVector == 16'h0000) || (irqVector == 16'h0008) || (irqVector == 16'h0010) ||
    (irqVector == 16'h0018) || (irqVector == 16'h0020));

endmodule

bind irq_vec_top irq_vec_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .regWrData  (regWrData),
  .irqAck     (irqAck),
  .irqRet     (irqRet),
  .irqReq     (irqReq),
  .irqVector  (irqVector),
  .glbDisable (glbDisable)
);

// File: tb/irq_vec_top_tb.sv
`timescale 1ns/1ps
module irq_vec_top_tb;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evtPin = 1'b0, evtTimer = 1'b0, evtClkEdge = 1'b0;
  logic [NP-1:0] periphFlagSet = '0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [7:0]    regWrData = 8'h00;
  logic [7:0]    regRdData;
  logic          irqAck = 1'b0, irqRet = 1'b0;
  logic          irqReq;
  logic [15:0]   irqVector;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_vec_top u_dut (
    .clk(clk), .rstN(rstN), .evtPin(evtPin), .evtTimer(evtTimer),
    .evtClkEdge(evtClkEdge), .periphFlagSet(periphFlagSet),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .irqAck(irqAck), .irqRet(irqRet),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  // {ctrl[7:0], events{pin,timer,clk,periph0}[3:0], periphEn[3:0], expReq, expVec[15:0]}
  localparam logic [32:0] TBL [9] = '{
    {8'h1E, 4'b1111, 4'h1, 1'b1, 16'h0008},  // all pending: pin wins
    {8'h1E, 4'b0110, 4'h1, 1'b1, 16'h0010},  // timer over clock edge
    {8'h1E, 4'b0011, 4'h1, 1'b1, 16'h0018},  // clock edge over group
    {8'h1E, 4'b0001, 4'h1, 1'b1, 16'h0020},  // group alone
    {8'h1C, 4'b0001, 4'h1, 1'b0, 16'h0000},  // group enable off
    {8'h1E, 4'b0001, 4'h0, 1'b0, 16'h0000},  // peripheral enable off
    {8'h0A, 4'b1100, 4'h0, 1'b1, 16'h0010},  // pin flagged but disabled
    {8'h16, 4'b0100, 4'h0, 1'b0, 16'h0000},  // timer disabled
    {8'h12, 4'b1011, 4'h1, 1'b1, 16'h0018}   // pin disabled, clock edge over group
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] s, output logic [7:0] d);
    regSel = s;
    #1;
    d = regRdData;
  endtask

  task automatic fire(input logic [3:0] ev);
    @(negedge clk);
    evtPin = ev[3]; evtTimer = ev[2]; evtClkEdge = ev[1]; periphFlagSet[0] = ev[0];
    @(negedge clk);
    evtPin = 1'b0; evtTimer = 1'b0; evtClkEdge = 1'b0; periphFlagSet = '0;
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic pulseRet();
    @(negedge clk); irqRet = 1'b1;
    @(negedge clk); irqRet = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] vHold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(2'd0, rd); check(rd == 8'h01, "R1 ctrl after reset", rd, 8'h01);
    rdReg(2'd1, rd); check(rd == 8'h00, "R1 flags after reset", rd, 8'h00);
    rdReg(2'd3, rd); check(rd == 8'h00, "R1 periph enables after reset", rd, 8'h00);
    check(irqReq == 1'b0, "R1 request after reset", irqReq, 0);
    check(irqVector == 16'h0, "R1 vector after reset", irqVector, 0);

    // R3 flag set while everything disabled; R2 no request
    fire(4'b1000);
    rdReg(2'd1, rd); check(rd[0] == 1'b1, "R3 pin flag while disabled", rd, 8'h01);
    check(irqReq == 1'b0, "R2 no request while disabled", irqReq, 0);
    wrReg(2'd0, 8'h05);
    check(irqReq == 1'b0, "R2 still no request with disable set", irqReq, 0);

    // R8 group flag read-only
    wrReg(2'd1, 8'h08);
    rdReg(2'd1, rd); check(rd == 8'h00, "R8 group flag not writable", rd, 8'h00);

    // Table walk: R6, R7, R8, R2, R4
    foreach (TBL[k]) begin
      logic [7:0]  ctrl;
      logic [3:0]  ev;
      logic [3:0]  pen;
      logic        expReq;
      logic [15:0] expVec;
      {ctrl, ev, pen, expReq, expVec} = TBL[k];
      wrReg(2'd0, ctrl | 8'h01);
      wrReg(2'd3, {4'h0, pen});
      wrReg(2'd1, 8'h00);
      wrReg(2'd2, 8'h00);
      fire(ev);
      wrReg(2'd0, ctrl & 8'hFE);
      check(irqReq == expReq, $sformatf("R2/R8 request entry %0d", k), irqReq, expReq);
      if (expReq) begin
        pulseAck();
        check(irqVector == expVec, $sformatf("R6/R7 vector entry %0d", k), irqVector, expVec);
        rdReg(2'd0, rd);
        check(rd[0] == 1'b1 && irqReq == 1'b0, $sformatf("R4 disable after accept entry %0d", k), rd, 1);
        pulseRet();
        rdReg(2'd0, rd);
        check(rd[0] == 1'b0, $sformatf("R5 return clears disable entry %0d", k), rd, 0);
      end
    end

    // R9 peripheral flag left set re-requests after return
    wrReg(2'd0, 8'h03);
    wrReg(2'd1, 8'h00);
    wrReg(2'd2, 8'h00);
    wrReg(2'd3, 8'h02);
    @(negedge clk); periphFlagSet = 4'b0010; @(negedge clk); periphFlagSet = '0;
    rdReg(2'd1, rd); check(rd[3] == 1'b1, "R8 group flag reflects enabled peripheral", rd, 8'h08);
    wrReg(2'd0, 8'h02);
    pulseAck();
    check(irqVector == 16'h0020, "R9 group vector", irqVector, 16'h0020);
    pulseRet();
    check(irqReq == 1'b1, "R9 flag left set requests again", irqReq, 1);
    rdReg(2'd2, rd); check(rd[1] == 1'b1, "R9 flag not cleared by hardware", rd, 8'h02);

    // R3 event beats same-cycle software clear
    @(negedge clk);
    regWrEn = 1'b1; regSel = 2'd1; regWrData = 8'h00; evtTimer = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; evtTimer = 1'b0;
    rdReg(2'd1, rd); check(rd[1] == 1'b1, "R3 event wins over clear", rd, 8'h02);

    // R10 vector held while a higher source becomes pending
    wrReg(2'd0, 8'h0D);               // pin+timer enabled, disabled globally
    wrReg(2'd1, 8'h02);               // timer flag only
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'h0C);
    pulseAck();
    check(irqVector == 16'h0010, "R10 timer vector taken", irqVector, 16'h0010);
    fire(4'b1000);
    pulseRet();
    check(irqVector == 16'h0010, "R10 vector held before next accept", irqVector, 16'h0010);
    pulseAck();
    check(irqVector == 16'h0008, "R10 vector moves on accept", irqVector, 16'h0008);

    // R4 acknowledge without request ignored
    vHold = irqVector;
    pulseAck();
    check(irqVector == vHold, "R4 stray acknowledge ignored", irqVector, vHold);

    // R11 disable-setting write collides with acknowledge
    pulseRet();
    check(irqReq == 1'b1, "R11 precondition request", irqReq, 1);
    wrReg(2'd1, 8'h02);               // timer only now
    @(negedge clk);
    irqAck = 1'b1; regWrEn = 1'b1; regSel = 2'd0; regWrData = 8'h0D;
    @(negedge clk);
    irqAck = 1'b0; regWrEn = 1'b0;
    check(irqVector == 16'h0008, "R11 acknowledge not accepted", irqVector, 16'h0008);
    rdReg(2'd0, rd); check(rd[0] == 1'b1 && irqReq == 1'b0, "R11 disable stays set", rd, 8'h0D);
    pulseRet();
    rdReg(2'd0, rd); check(rd == 8'h0C, "R12 control readback", rd, 8'h0C);

    summary();
  end

endmodule